// File: doc/BRIEF.md
# Sprite Layer Priority Select with Sprite-Zero Hit Latch

This block sits between a bank of sprite pixel units and the layer compositor. On every pixel clock each sprite unit offers a 5-bit slot value: one priority bit, a 2-bit colour-set field and a 2-bit pixel value. A slot counts as opaque when its pixel value is non-zero. The block picks the opaque slot with the lowest unit index and presents that slot's 4-bit colour, its priority bit and a sprite-opacity flag. All of this is combinational, so the result follows the inputs within the same pixel clock.

A single registered flag records a sprite-zero hit. On a pixel-enabled cycle where unit 0 is marked in range, the flag sets if unit 0 and the background are both opaque. It then stays set until a frame-clear pulse or reset. Compositing the chosen sprite against the background is left to a later stage.

Top module: `sprite_layer_arbiter`

## Requirements
- R1: A unit is opaque exactly when its 2-bit pixel value (slot bits [1:0]) is non-zero. A unit with pixel value 0 never wins, whatever its colour-set and priority bits hold.
- R2: When several units are opaque, the one with the lowest index wins. Unit u occupies bits [5u+4:5u] of `unit_val`.
- R3: `lay_color` equals the winner's {colour set, pixel} (slot bits [3:0]) and `lay_pri` equals the winner's slot bit 4. `lay_opaque` is 1.
- R4: When no unit is opaque, `lay_opaque`, `lay_color` and `lay_pri` are all 0.
- R5: A cycle with `pix_en`, `zero_in_range`, `bg_opaque` and unit 0 opacity all high, and `frame_clr` low, makes `zero_hit` 1 after the next rising clock edge.
- R6: With `zero_in_range` low, no stimulus sets `zero_hit`.
- R7: With `pix_en` low, no stimulus sets `zero_hit`.
- R8: `zero_hit` is not set when the background is transparent, or when unit 0 is transparent even though other units are opaque.
- R9: Once set, `zero_hit` holds until a cycle with `frame_clr` high clears it at the next edge. A clear wins over a simultaneous set.
- R10: A clock edge with `rst_n` low forces `zero_hit` to 0.
- R11: The layer outputs change in the same cycle as `unit_val`, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Marks cycles that carry a visible pixel |
| frame_clr | input | 1 | Clears the sprite-zero hit flag |
| zero_in_range | input | 1 | Unit 0 holds the sprite-zero on this line |
| bg_opaque | input | 1 | Background pixel is non-transparent |
| unit_val | input | NUM_UNITS*5 | Packed slot values, unit 0 in the lowest bits |
| lay_color | output | 4 | Colour of the frontmost opaque sprite |
| lay_pri | output | 1 | Priority bit of the frontmost opaque sprite |
| lay_opaque | output | 1 | At least one unit is opaque |
| zero_hit | output | 1 | Sticky sprite-zero hit flag |

## Verification
The bench builds the block with the default of eight units and the fixed 2-bit pixel and colour-set fields. With eight units, a single table can place the winner at unit 0, at an interior unit and at unit 7. It can also cover every unit being opaque at once and the case where every unit is transparent but still carries non-zero colour-set and priority bits. Directed sequences then clear each term of the hit condition in turn, hold the flag sticky, and check a clear that collides with a set as well as a reset of a set flag.

// File: rtl/sprite_arb_pkg.sv
// Package: shared slot layout for the sprite layer arbiter.
// Assumes a fixed 2-bit pixel value and 2-bit colour-set field per unit.
package sprite_arb_pkg;

    localparam int unsigned PIX_BITS = 2;
    localparam int unsigned PAL_BITS = 2;
    localparam int unsigned COLOR_W  = PAL_BITS + PIX_BITS;
    localparam int unsigned SLOT_W   = COLOR_W + 1;

    // One sprite unit's per-pixel offer; field order sets the packed bit layout.
    typedef struct packed {
        logic                pri;
        logic [PAL_BITS-1:0] pal;
        logic [PIX_BITS-1:0] pix;
    } spr_slot_t;

endpackage

// File: rtl/spr_opacity_scan.sv
// Module: spr_opacity_scan
// Derives one opacity bit per unit and encodes the lowest-index opaque unit.
// Assumes unit 0 is the front of the list; purely combinational.
module spr_opacity_scan
    import sprite_arb_pkg::*;
#(
    parameter int unsigned NUM_UNITS = 8,
    localparam int unsigned IDX_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  spr_slot_t        slots [NUM_UNITS],
    output logic [NUM_UNITS-1:0] opq_vec,
    output logic [IDX_W-1:0] win_idx,
    output logic             any_opq
);

    // Per-unit opacity: any non-zero pixel bit.
    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_opq
        assign opq_vec[g] = |slots[g].pix;
    end

    // Priority encode: scan from the back so the lowest opaque index is kept.
    always_comb begin
        win_idx = '0;
        for (int i = NUM_UNITS - 1; i >= 0; i--) begin
            if (opq_vec[i]) begin
                win_idx = IDX_W'(i);
            end
        end
    end

    // Any-opaque flag for the output gate.
    assign any_opq = |opq_vec;

endmodule

// File: rtl/spr_layer_mux.sv
// Module: spr_layer_mux
// Selects the winning unit's colour and priority; forces zeros when none is opaque.
// Assumes win_idx is only meaningful while any_opq is high.
module spr_layer_mux
    import sprite_arb_pkg::*;
#(
    parameter int unsigned NUM_UNITS = 8,
    localparam int unsigned IDX_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  spr_slot_t          slots [NUM_UNITS],
    input  logic [IDX_W-1:0]   win_idx,
    input  logic               any_opq,
    output logic [COLOR_W-1:0] color,
    output logic               pri,
    output logic               opaque
);

    spr_slot_t picked;

    // Indexed select across all units.
    always_comb begin
        picked = '0;
        for (int i = 0; i < NUM_UNITS; i++) begin
            if (win_idx == IDX_W'(i)) begin
                picked = slots[i];
            end
        end
    end

    // Output gate: a transparent layer presents all zeros.
    always_comb begin
        if (any_opq) begin
            color  = {picked.pal, picked.pix};
            pri    = picked.pri;
            opaque = 1'b1;
        end else begin
            color  = '0;
            pri    = 1'b0;
            opaque = 1'b0;
        end
    end

endmodule

// File: rtl/spr_zero_hit.sv
// Module: spr_zero_hit
// Sticky sprite-zero hit flag; set by overlap of unit 0 and background on enabled pixels.
// Assumes a synchronous active-low reset; clear has precedence over set.
module spr_zero_hit (
    input  logic clk,
    input  logic rst_n,
    input  logic pix_en,
    input  logic frame_clr,
    input  logic zero_in_range,
    input  logic u0_opq,
    input  logic bg_opq,
    output logic hit
);

    logic set_req;

    // Hit condition for this pixel.
    assign set_req = pix_en & zero_in_range & u0_opq & bg_opq;

    // Flag register: reset, then clear, then set, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit <= 1'b0;
        end else if (frame_clr) begin
            hit <= 1'b0;
        end else if (set_req) begin
            hit <= 1'b1;
        end
    end

    // R9
    hit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_clr |=> !hit);

    // R9
    hit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !frame_clr) |=> hit);

    // R5
    hit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && zero_in_range && u0_opq && bg_opq && !frame_clr) |=> hit);

    // R6
    hit_range_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !zero_in_range) |=> !hit);

    // R7
    hit_enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !pix_en) |=> !hit);

endmodule

// File: rtl/sprite_layer_arbiter.sv
// Module: sprite_layer_arbiter
// Top: unpacks unit slots, picks the frontmost opaque sprite and tracks sprite-zero hits.
// Assumes slot u sits at unit_val[5u+4:5u]; layer path is combinational.
module sprite_layer_arbiter
    import sprite_arb_pkg::*;
#(
    parameter int unsigned NUM_UNITS = 8,
    localparam int unsigned IDX_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    localparam int unsigned VAL_W    = NUM_UNITS * SLOT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_en,
    input  logic               frame_clr,
    input  logic               zero_in_range,
    input  logic               bg_opaque,
    input  logic [VAL_W-1:0]   unit_val,
    output logic [COLOR_W-1:0] lay_color,
    output logic               lay_pri,
    output logic               lay_opaque,
    output logic               zero_hit
);

    spr_slot_t              slots [NUM_UNITS];
    logic [NUM_UNITS-1:0]   opq_vec;
    logic [IDX_W-1:0]       win_idx;
    logic                   any_opq;

    // Slot unpacking, one field group per unit.
    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unpack
        assign slots[g] = unit_val[g*SLOT_W +: SLOT_W];
    end

    spr_opacity_scan #(.NUM_UNITS(NUM_UNITS)) u_scan (
        .slots   (slots),
        .opq_vec (opq_vec),
        .win_idx (win_idx),
        .any_opq (any_opq)
    );

    spr_layer_mux #(.NUM_UNITS(NUM_UNITS)) u_mux (
        .slots   (slots),
        .win_idx (win_idx),
        .any_opq (any_opq),
        .color   (lay_color),
        .pri     (lay_pri),
        .opaque  (lay_opaque)
    );

    spr_zero_hit u_hit (
        .clk           (clk),
        .rst_n         (rst_n),
        .pix_en        (pix_en),
        .frame_clr     (frame_clr),
        .zero_in_range (zero_in_range),
        .u0_opq        (opq_vec[0]),
        .bg_opq        (bg_opaque),
        .hit           (zero_hit)
    );

    // R4
    empty_layer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lay_opaque |-> (lay_color == '0 && !lay_pri));

    // R2
    winner_opaque_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lay_opaque |-> opq_vec[win_idx]);

    // R3
    winner_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lay_opaque |-> (lay_color == {slots[win_idx].pal, slots[win_idx].pix}));

endmodule

// File: tb/sprite_layer_arbiter_tb.sv
`timescale 1ns/1ps
module sprite_layer_arbiter_tb;

    localparam int N  = 8;
    localparam int VW = N * 5;
    localparam int NV = 9;

    logic          clk = 1'b0;
    logic          rst_n, pix_en, frame_clr, zero_in_range, bg_opaque;
    logic [VW-1:0] unit_val;
    logic [3:0]    lay_color;
    logic          lay_pri, lay_opaque, zero_hit;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done  = 1'b0;

    always #4 clk = ~clk;

    sprite_layer_arbiter #(.NUM_UNITS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .frame_clr(frame_clr),
        .zero_in_range(zero_in_range), .bg_opaque(bg_opaque), .unit_val(unit_val),
        .lay_color(lay_color), .lay_pri(lay_pri), .lay_opaque(lay_opaque),
        .zero_hit(zero_hit)
    );

    // slot value {pri, pal[1:0], pix[1:0]} placed at unit idx
    function automatic logic [VW-1:0] u(int idx, logic [4:0] v);
        return VW'(v) << (5 * idx);
    endfunction

    // entry: {unit_val, exp color, exp pri, exp opaque}
    localparam logic [VW+5:0] VECS [NV] = '{
        {VW'(0), 4'h0, 1'b0, 1'b0},                                   // R4 empty
        {u(7, 5'b1_10_11), 4'b1011, 1'b1, 1'b1},                     // R2 last unit alone
        {u(3, 5'b0_01_01) | u(5, 5'b1_11_10), 4'b0101, 1'b0, 1'b1}, // R2 interior
        {u(0, 5'b1_00_10) | u(1, 5'b0_11_11), 4'b0010, 1'b1, 1'b1}, // R2 unit 0 wins
        {u(0, 5'b1_11_00) | u(2, 5'b0_10_01), 4'b1001, 1'b0, 1'b1}, // R1 transparent unit 0
        {{N{5'b1_11_00}}, 4'h0, 1'b0, 1'b0},                         // R1 R4 all transparent
        {{{(N-1){5'b0_01_11}}, 5'b1_10_01}, 4'b1001, 1'b1, 1'b1},   // R2 all opaque
        {u(6, 5'b0_00_01) | u(7, 5'b1_11_11), 4'b0001, 1'b0, 1'b1}, // R3 pal zero
        {u(2, 5'b1_11_00) | u(4, 5'b0_11_10), 4'b1110, 1'b0, 1'b1}  // R1 R3
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_hit_in(logic en, logic rng, logic bg, logic clr, logic [VW-1:0] v);
        pix_en = en; zero_in_range = rng; bg_opaque = bg; frame_clr = clr; unit_val = v;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R5 watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        set_hit_in(1'b1, 1'b1, 1'b1, 1'b0, u(0, 5'b0_00_11));
        step(); step();
        check("R10 reset hit", 32'(zero_hit), 32'd0);
        rst_n = 1'b1;
        set_hit_in(1'b0, 1'b0, 1'b0, 1'b0, '0);
        step();

        // R11 table: outputs checked 1 ns after inputs, no edge in between
        for (int i = 0; i < NV; i++) begin
            unit_val = VECS[i][VW+5:6];
            #1;
            check($sformatf("R11 R3 table %0d color", i), 32'(lay_color), 32'(VECS[i][5:2]));
            check($sformatf("R3 table %0d pri", i), 32'(lay_pri), 32'(VECS[i][1]));
            check($sformatf("R4 R2 table %0d opaque", i), 32'(lay_opaque), 32'(VECS[i][0]));
            step();
        end

        // hit gating
        set_hit_in(1'b0, 1'b1, 1'b1, 1'b0, u(0, 5'b0_00_01)); step();
        check("R7 no set without pix_en", 32'(zero_hit), 32'd0);
        set_hit_in(1'b1, 1'b0, 1'b1, 1'b0, u(0, 5'b0_00_01)); step();
        check("R6 no set out of range", 32'(zero_hit), 32'd0);
        set_hit_in(1'b1, 1'b1, 1'b0, 1'b0, u(0, 5'b0_00_01)); step();
        check("R8 no set bg transparent", 32'(zero_hit), 32'd0);
        set_hit_in(1'b1, 1'b1, 1'b1, 1'b0, u(0, 5'b1_11_00) | u(1, 5'b0_00_11)); step();
        check("R8 no set unit0 transparent", 32'(zero_hit), 32'd0);
        set_hit_in(1'b1, 1'b1, 1'b1, 1'b0, u(0, 5'b0_00_10)); step();
        check("R5 hit set", 32'(zero_hit), 32'd1);
        set_hit_in(1'b0, 1'b0, 1'b0, 1'b0, '0); step(); step();
        check("R9 sticky", 32'(zero_hit), 32'd1);
        set_hit_in(1'b1, 1'b1, 1'b1, 1'b1, u(0, 5'b0_00_10)); step();
        check("R9 clear beats set", 32'(zero_hit), 32'd0);
        set_hit_in(1'b0, 1'b0, 1'b0, 1'b0, '0); step();
        check("R9 stays clear", 32'(zero_hit), 32'd0);
        set_hit_in(1'b1, 1'b1, 1'b1, 1'b0, u(0, 5'b0_00_01)); step();
        check("R5 hit set again", 32'(zero_hit), 32'd1);
        set_hit_in(1'b0, 1'b0, 1'b0, 1'b0, '0);
        rst_n = 1'b0; step();
        check("R10 reset clears hit", 32'(zero_hit), 32'd0);
        rst_n = 1'b1; step();

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule